// File: doc/BRIEF.md
# Watchdog Frequency Recovery Controller

This block guards frequency changes in a programmable clock generator. Software programs the generator's divider setting through a small register port. The setting is either an N/M divider pair or a select code. Before a risky change, software arms a watchdog that counts timebase ticks down from a programmed timeout. If the system hangs and the count runs out, the block does two things. It pulls a system reset request low for a fixed number of ticks. It also forces the active divider setting to a recovery setting.

While in recovery, the block discards every register write that could move the output frequency. It stays in recovery until software writes the watchdog enable bit back to 0. The recovery setting has two possible sources, chosen by a control bit:
- the select code sampled from the strap pins right after reset, or
- a pair of recovery N/M registers.

A separate control bit makes every accepted frequency write also raise the reset pulse.

Register map (address on `wr_addr_i`, data on `wr_data_i`):
- 0, control: bit0 arms the watchdog, bit1 picks the recovery source (1 = recovery N/M, 0 = strap code), bit2 enables reset on frequency writes.
- 1: timeout in ticks.
- 2: recovery N.
- 3: recovery M.
- 4: working N.
- 5: working M.
- 6, mode: bit0 = 1 selects N/M output, bits[5:1] hold the working select code.

Top module: `wdog_freq_guard`

## Requirements
- R1: In the first clock after reset, the strap code on `pin_code_i` is captured into a latch and into the working select code; later pin changes have no effect. At reset, `act_n_o`/`act_m_o` read 0, `act_nm_o` reads 0, `sys_rst_n_o` is 1 and `wd_fired_o` is 0.
- R2: Outside recovery, the outputs show the working registers: `act_n_o` from address 4, `act_m_o` from address 5, and `act_nm_o` and `act_sel_o` from bit0 and bits[5:1] of address 6. A write takes effect on the outputs in the cycle after it.
- R3: Once armed with timeout T, the watchdog fires on the T-th tick, or on the first tick when T is 0. Ticks while disarmed have no effect.
- R4: When the watchdog fires, `wd_fired_o` goes to 1 and stays at 1 until the enable bit is cleared, whatever ticks follow.
- R5: In recovery, `act_sel_o` shows the strap code latched after reset. With source bit 1, `act_nm_o` is 1 and N/M come from addresses 2 and 3. With source bit 0, `act_nm_o` is 0 and N/M keep their working values.
- R6: In recovery, writes to addresses 2 to 6, and to the source bit, are ignored. They change no output and raise no reset.
- R7: Firing pulls `sys_rst_n_o` low in the cycle after the expiring tick. It stays low for 16 ticks and returns high on the 16th tick.
- R8: With control bit2 set, an accepted write to address 4, 5 or 6 starts the same 16-tick low pulse on `sys_rst_n_o`.
- R9: Writing the control register with bit0 = 0 leaves recovery and clears `wd_fired_o`. The outputs return to the working registers in the next cycle.
- R10: Every control write with bit0 = 1 reloads the countdown from the timeout register, even when the watchdog is already armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| pin_code_i | input | 5 | Strap pin select code |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| act_n_o | output | 8 | Active N divider |
| act_m_o | output | 7 | Active M divider |
| act_sel_o | output | 5 | Active select code |
| act_nm_o | output | 1 | 1 = N/M drives the output frequency, 0 = select code |
| sys_rst_n_o | output | 1 | Active-low system reset request |
| wd_fired_o | output | 1 | Watchdog has fired (recovery active) |

## Verification
The bench arms the watchdog with a timeout of 3 and checks that nothing happens after two ticks. A design off by one would fire early or late. It uses a timeout of 0 to catch a counter that wraps instead of firing at once. It re-arms the watchdog mid-count to catch a countdown that ignores the reload. It writes working and recovery registers during recovery, with reset-on-write enabled, to catch a lockout that leaks a frequency change or a stray reset. It counts the reset pulse tick by tick to expose a short or long pulse. The strap pins are changed after capture, and the working select code differs from the strap code. This exposes a design that reads the live pins or picks the wrong source in recovery.

// File: rtl/wdog_freq_guard.sv
module wdog_freq_guard #(
  parameter int N_W = 8,
  parameter int M_W = 7,
  parameter int SEL_W = 5,
  parameter int TO_W = 8,
  parameter int PULSE_TICKS = 16,
  parameter int AW = 3,
  localparam int DW0 = (N_W > M_W) ? N_W : M_W,
  localparam int DW1 = (DW0 > TO_W) ? DW0 : TO_W,
  localparam int DW2 = (DW1 > SEL_W + 1) ? DW1 : SEL_W + 1,
  localparam int DW = (DW2 > 3) ? DW2 : 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] pin_code_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [N_W-1:0]   act_n_o,
  output logic [M_W-1:0]   act_m_o,
  output logic [SEL_W-1:0] act_sel_o,
  output logic             act_nm_o,
  output logic             sys_rst_n_o,
  output logic             wd_fired_o
);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_TMO  = AW'(1);
  localparam logic [AW-1:0] A_RN   = AW'(2);
  localparam logic [AW-1:0] A_RM   = AW'(3);
  localparam logic [AW-1:0] A_SN   = AW'(4);
  localparam logic [AW-1:0] A_SM   = AW'(5);
  localparam logic [AW-1:0] A_MODE = AW'(6);

  logic             captured_q, armed_q, src_nm_q, chg_rst_q, fired_q, sw_nm_q;
  logic [SEL_W-1:0] pin_q, sw_sel_q;
  logic [TO_W-1:0]  tmo_q, cnt_q;
  logic [N_W-1:0]   rec_n_q, sw_n_q;
  logic [M_W-1:0]   rec_m_q, sw_m_q;
  logic [PW-1:0]    pulse_q;

  wire wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
  wire wr_sn    = wr_en_i && !fired_q && (wr_addr_i == A_SN);
  wire wr_sm    = wr_en_i && !fired_q && (wr_addr_i == A_SM);
  wire wr_mode  = wr_en_i && !fired_q && (wr_addr_i == A_MODE);
  wire wr_rn    = wr_en_i && !fired_q && (wr_addr_i == A_RN);
  wire wr_rm    = wr_en_i && !fired_q && (wr_addr_i == A_RM);
  wire counting = armed_q && !fired_q && tick_i && !wr_ctrl;
  wire expire   = counting && (cnt_q <= TO_W'(1));
  wire freq_chg = (wr_sn || wr_sm || wr_mode) && chg_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured_q <= 1'b0;
      pin_q      <= '0;
      sw_sel_q   <= '0;
    end else begin
      if (!captured_q) begin
        captured_q <= 1'b1;
        pin_q      <= pin_code_i;
        sw_sel_q   <= pin_code_i;
      end else if (wr_mode) begin
        sw_sel_q   <= wr_data_i[SEL_W:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      src_nm_q  <= 1'b0;
      chg_rst_q <= 1'b0;
      fired_q   <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        armed_q   <= wr_data_i[0];
        chg_rst_q <= wr_data_i[2];
        if (!fired_q) src_nm_q <= wr_data_i[1];
        if (wr_data_i[0]) cnt_q <= tmo_q;
        else fired_q <= 1'b0;
      end else begin
        if (expire) fired_q <= 1'b1;
        if (counting && cnt_q != '0) cnt_q <= cnt_q - TO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= '0;
      rec_n_q <= '0;
      rec_m_q <= '0;
      sw_n_q  <= '0;
      sw_m_q  <= '0;
      sw_nm_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_TMO) tmo_q <= wr_data_i[TO_W-1:0];
      if (wr_rn)   rec_n_q <= wr_data_i[N_W-1:0];
      if (wr_rm)   rec_m_q <= wr_data_i[M_W-1:0];
      if (wr_sn)   sw_n_q  <= wr_data_i[N_W-1:0];
      if (wr_sm)   sw_m_q  <= wr_data_i[M_W-1:0];
      if (wr_mode) sw_nm_q <= wr_data_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else if (expire || freq_chg) pulse_q <= PW'(PULSE_TICKS);
    else if (tick_i && pulse_q != '0) pulse_q <= pulse_q - PW'(1);
  end

  wire use_rec_nm = fired_q && src_nm_q;

  assign act_n_o     = use_rec_nm ? rec_n_q : sw_n_q;
  assign act_m_o     = use_rec_nm ? rec_m_q : sw_m_q;
  assign act_sel_o   = fired_q ? pin_q : sw_sel_q;
  assign act_nm_o    = fired_q ? src_nm_q : sw_nm_q;
  assign sys_rst_n_o = (pulse_q == '0);
  assign wd_fired_o  = fired_q;
endmodule

// File: rtl/wdog_freq_guard_chk.sv
module wdog_freq_guard_chk #(
  parameter int N_W = 8,
  parameter int M_W = 7,
  parameter int SEL_W = 5,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [N_W-1:0]   act_n_o,
  input logic [M_W-1:0]   act_m_o,
  input logic [SEL_W-1:0] act_sel_o,
  input logic             act_nm_o,
  input logic             sys_rst_n_o,
  input logic             wd_fired_o
);
  p_rst_on_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_fired_o) |-> !sys_rst_n_o);

  p_fire_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_fired_o) |-> $past(tick_i));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fired_o && $past(wd_fired_o)) |->
      ($stable(act_n_o) && $stable(act_m_o) && $stable(act_sel_o) && $stable(act_nm_o)));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_fired_o) |-> $past(wr_en_i && wr_addr_i == '0 && !wr_data_i[0]));
endmodule

bind wdog_freq_guard wdog_freq_guard_chk #(
  .N_W(N_W), .M_W(M_W), .SEL_W(SEL_W), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .act_n_o(act_n_o),
  .act_m_o(act_m_o), .act_sel_o(act_sel_o), .act_nm_o(act_nm_o),
  .sys_rst_n_o(sys_rst_n_o), .wd_fired_o(wd_fired_o)
);

// File: tb/tb_wdog_freq_guard.sv
module tb_wdog_freq_guard;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [4:0] pin = 5'h13;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] n;
  logic [6:0] m;
  logic [4:0] sel;
  logic nm, srst_n, fired;
  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct {
    string tag; logic [7:0] n; logic [6:0] m; logic [4:0] sel;
    logic nm; logic rstn; logic fired;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  wdog_freq_guard dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pin_code_i(pin),
    .wr_en_i(wr_en), .wr_addr_i(addr), .wr_data_i(data),
    .act_n_o(n), .act_m_o(m), .act_sel_o(sel), .act_nm_o(nm),
    .sys_rst_n_o(srst_n), .wd_fired_o(fired)
  );

  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if ({n, m, sel, nm, srst_n, fired} !== {e.n, e.m, e.sel, e.nm, e.rstn, e.fired}) begin
          fails++;
          $display("FAIL %s: got n=%h m=%h sel=%h nm=%b rst_n=%b fired=%b, exp n=%h m=%h sel=%h nm=%b rst_n=%b fired=%b",
            e.tag, n, m, sel, nm, srst_n, fired, e.n, e.m, e.sel, e.nm, e.rstn, e.fired);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic expect_out(input string tag, input logic [7:0] en, input logic [6:0] em,
                            input logic [4:0] es, input logic enm, input logic er, input logic ef);
    exp_t e;
    e.tag = tag; e.n = en; e.m = em; e.sel = es; e.nm = enm; e.rstn = er; e.fired = ef;
    q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    pin = 5'h04;
    expect_out("R1 reset and strap capture", 8'h00, 7'h00, 5'h13, 0, 1, 0);

    wr(3'd4, 8'h80); wr(3'd5, 8'h30); wr(3'd6, 8'h15);
    expect_out("R2 working registers", 8'h80, 7'h30, 5'h0A, 1, 1, 0);

    wr(3'd0, 8'h04); wr(3'd4, 8'h90);
    expect_out("R8 reset on frequency write", 8'h90, 7'h30, 5'h0A, 1, 0, 0);
    ticks(15);
    expect_out("R7 pulse still low after 15 ticks", 8'h90, 7'h30, 5'h0A, 1, 0, 0);
    ticks(1);
    expect_out("R7 pulse ends on 16th tick", 8'h90, 7'h30, 5'h0A, 1, 1, 0);

    wr(3'd0, 8'h00); wr(3'd1, 8'h03); wr(3'd2, 8'hA5); wr(3'd3, 8'h5A);
    ticks(20);
    expect_out("R3 ticks ignored while disarmed", 8'h90, 7'h30, 5'h0A, 1, 1, 0);
    wr(3'd0, 8'h03);
    ticks(2);
    expect_out("R3 no fire before T ticks", 8'h90, 7'h30, 5'h0A, 1, 1, 0);
    ticks(1);
    expect_out("R4 R5 fire to recovery N/M", 8'hA5, 7'h5A, 5'h13, 1, 0, 1);

    wr(3'd4, 8'h11);
    expect_out("R6 write ignored in recovery", 8'hA5, 7'h5A, 5'h13, 1, 0, 1);
    ticks(16);
    expect_out("R4 R7 status held, pulse over", 8'hA5, 7'h5A, 5'h13, 1, 1, 1);
    wr(3'd0, 8'h07); wr(3'd4, 8'h11); wr(3'd2, 8'h22); wr(3'd6, 8'h00);
    expect_out("R6 no change and no reset in recovery", 8'hA5, 7'h5A, 5'h13, 1, 1, 1);

    wr(3'd0, 8'h02);
    expect_out("R9 release restores working setting", 8'h90, 7'h30, 5'h0A, 1, 1, 0);

    wr(3'd1, 8'h00); wr(3'd0, 8'h01);
    ticks(1);
    expect_out("R5 R3 strap source, zero timeout", 8'h90, 7'h30, 5'h13, 0, 0, 1);
    ticks(16);

    wr(3'd0, 8'h00); wr(3'd1, 8'h04); wr(3'd0, 8'h01);
    ticks(3);
    wr(3'd0, 8'h01);
    ticks(3);
    expect_out("R10 reload delays fire", 8'h90, 7'h30, 5'h0A, 1, 1, 0);
    ticks(1);
    expect_out("R10 fire after reloaded count", 8'h90, 7'h30, 5'h13, 0, 0, 1);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run hung, got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule